// File: doc/BRIEF.md
# UART DMA Ready Signal Generator

This block drives the two active-low handshake lines that a FIFO-equipped UART offers to a DMA controller or a polling host: `tx_rdy_n`, which asks for more transmit data, and `rx_rdy_n`, which announces that received data can be collected. It watches the occupancy of the transmit and receive queues, together with the receive trigger-reached and receive timeout flags produced next to the receive FIFO. From these it forms the two lines according to the transfer mode that is selected.

In single-transfer mode the lines follow plain empty and non-empty tests. In block-transfer mode transmit-ready is asserted while any transmit slot is free. Receive-ready is armed by the trigger flag or a timeout, and it stays asserted until the receive FIFO has been emptied. The block also holds the FIFO control settings: the enable, the mode select, the receive trigger selection and the two flush commands. A control write changes the mode, trigger and flush fields only when it also writes the enable bit as 1. The FIFOs themselves and the interrupt encoding live elsewhere.

Top module: `uart_dma_ready_gen`

## Requirements
- R1: After reset `fifo_on`=0, `dma_sel`=0, `trig_sel`=0, `rx_flush`=0, `tx_flush`=0, `tx_rdy_n`=0 and `rx_rdy_n`=1.
- R2: Block mode is in force only while `fifo_on`=1 and `dma_sel`=1. A write of 0x00 after 0x09 leaves `dma_sel`=1, but the lines then follow single-transfer rules.
- R3: In single-transfer mode `tx_rdy_n` is 0 when `tx_level`=0 and 1 when `tx_level` is non-zero.
- R4: In single-transfer mode `rx_rdy_n` is 0 when `rx_level` is non-zero and 1 when `rx_level`=0. The trigger and timeout flags have no effect on it.
- R5: In block mode `tx_rdy_n` is 1 only when `tx_level` equals DEPTH, and 0 otherwise.
- R6: In block mode `rx_rdy_n` goes to 0 when `rx_trig_hit` or `rx_timeout` is seen while `rx_level` is non-zero. It then stays 0, whatever the flags do, until `rx_level`=0, and then returns to 1.
- R7: In block mode a `rx_timeout` while `rx_level`=0 does not arm receive-ready. Data that arrives afterwards leaves `rx_rdy_n`=1 until a new trigger or timeout.
- R8: A control write (`ctl_wr`=1) always loads bit 0 of `ctl_wdata` into `fifo_on`. It loads bit 3 into `dma_sel` and bits 7:6 into `trig_sel`, and acts on flush bits 1 and 2, only when bit 0 of the same write is 1.
- R9: An accepted write with bit 1 set pulses `rx_flush` high for exactly one cycle. One with bit 2 set does the same on `tx_flush`.
- R10: An `rx_flush` pulse clears the block-mode receive arming, so `rx_rdy_n` returns to 1 even though `rx_level` is non-zero.
- R11: A change of transfer mode clears the receive arming. After leaving block mode and entering it again, `rx_rdy_n` is 1 until a new trigger or timeout.
- R12: Both ready lines are registered. They change on the first clock edge after the level or flag change, never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: bit0 enable, bit1 rx flush, bit2 tx flush, bit3 block mode, bits7:6 trigger select |
| tx_level | input | CW (5) | Characters held in the transmit FIFO or holding register |
| rx_level | input | CW (5) | Characters held in the receive FIFO |
| rx_trig_hit | input | 1 | Receive FIFO has reached its trigger level |
| rx_timeout | input | 1 | Receive timeout has occurred |
| tx_rdy_n | output | 1 | Transmit ready, active low |
| rx_rdy_n | output | 1 | Receive ready, active low |
| fifo_on | output | 1 | FIFO enable setting |
| dma_sel | output | 1 | Block-mode select setting |
| trig_sel | output | 2 | Receive trigger level selection |
| rx_flush | output | 1 | One-cycle receive FIFO clear command |
| tx_flush | output | 1 | One-cycle transmit FIFO clear command |

## Verification
The bench aims at the places where the two block-mode rules diverge. It checks that receive-ready stays low after the trigger flag drops while data remains. A design that followed the flag level would release the line too early. It also checks that a timeout seen on an empty FIFO leaves nothing armed, and that a flush or a mode round trip clears a stale arming; a design that kept the arming would claim data that was never announced. Writes with the enable bit cleared must leave the mode and trigger settings untouched. Level changes driven between edges must not appear on the ready lines before the next edge, so a combinational output path is caught.

// File: rtl/uart_rdy_pkg.sv
package uart_rdy_pkg;

   typedef enum logic {
      XFER_SINGLE = 1'b0,
      XFER_BLOCK  = 1'b1
   } xfer_mode_e;

   // Control word bit positions decoded by the FIFO neighbours
   localparam int unsigned CTL_EN_BIT    = 0;
   localparam int unsigned CTL_RXCLR_BIT = 1;
   localparam int unsigned CTL_TXCLR_BIT = 2;
   localparam int unsigned CTL_BLK_BIT   = 3;
   localparam int unsigned CTL_TRIG_LSB  = 6;
   localparam int unsigned CTL_TRIG_W    = 2;

   typedef struct packed {
      logic [CTL_TRIG_W-1:0] trig;
      logic                  blk;
      logic                  en;
   } ctl_state_t;

   function automatic xfer_mode_e mode_of(input ctl_state_t s);
      return (s.en && s.blk) ? XFER_BLOCK : XFER_SINGLE;
   endfunction

endpackage

// File: rtl/uart_rdy_ctl.sv
module uart_rdy_ctl
   import uart_rdy_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output ctl_state_t    state,
   output logic          rx_clr,
   output logic          tx_clr
);

   localparam int unsigned TOP_BIT = CTL_TRIG_LSB + CTL_TRIG_W - 1;

   generate
      if (DW <= TOP_BIT) begin : g_bad_dw
         $error("uart_rdy_ctl: DW too narrow for control fields");
      end
   endgenerate

   ctl_state_t state_q, state_d;
   logic       rx_clr_q, tx_clr_q;
   logic       accept;

   assign accept = wr && wdata[CTL_EN_BIT];

   always_comb begin
      state_d = state_q;
      if (wr) begin
         state_d.en = wdata[CTL_EN_BIT];
      end
      if (accept) begin
         state_d.blk  = wdata[CTL_BLK_BIT];
         state_d.trig = wdata[CTL_TRIG_LSB +: CTL_TRIG_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= '0;
         rx_clr_q <= 1'b0;
         tx_clr_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         rx_clr_q <= accept && wdata[CTL_RXCLR_BIT];
         tx_clr_q <= accept && wdata[CTL_TXCLR_BIT];
      end
   end

   assign state  = state_q;
   assign rx_clr = rx_clr_q;
   assign tx_clr = tx_clr_q;

   // R8: a write with the enable bit low keeps mode and trigger fields
   assert_gated_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wdata[CTL_EN_BIT]) |=> ($stable(state_q.blk) && $stable(state_q.trig)));

   // R9: flush commands last one cycle
   assert_clr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_clr_q && !wr) |=> !rx_clr_q);

endmodule

// File: rtl/uart_rdy_tx.sv
module uart_rdy_tx
   import uart_rdy_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  xfer_mode_e    mode,
   input  logic [CW-1:0] level,
   output logic          rdy_n
);

   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic full;
   logic empty;
   logic rdy_n_q;

   // Full detect: a power-of-two depth needs only the top bit
   generate
      if (POW2) begin : g_full_msb
         assign full = level[CW-1];
      end else begin : g_full_cmp
         assign full = (level == CW'(DEPTH));
      end
   endgenerate

   assign empty = (level == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_n_q <= 1'b0;
      end else if (mode == XFER_BLOCK) begin
         rdy_n_q <= full;
      end else begin
         rdy_n_q <= !empty;
      end
   end

   assign rdy_n = rdy_n_q;

   // R3: single mode, data present drops readiness
   assert_single_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XFER_SINGLE && level != '0) |=> rdy_n);

   // R5: block mode, a free slot keeps readiness
   assert_block_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XFER_BLOCK && level < CW'(DEPTH)) |=> !rdy_n);

   assert_block_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XFER_BLOCK && level == CW'(DEPTH)) |=> rdy_n);

endmodule

// File: rtl/uart_rdy_rx.sv
module uart_rdy_rx
   import uart_rdy_pkg::*;
#(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  xfer_mode_e    mode,
   input  logic          clr,
   input  logic [CW-1:0] level,
   input  logic          trig_hit,
   input  logic          tmo,
   output logic          rdy_n
);

   xfer_mode_e mode_prev_q;
   logic       arm_q, arm_d;
   logic       rdy_n_q, rdy_n_d;
   logic       empty;
   logic       mode_chg;

   assign empty    = (level == '0);
   assign mode_chg = (mode != mode_prev_q);

   always_comb begin
      arm_d = arm_q;
      if (mode != XFER_BLOCK || mode_chg || clr || empty) begin
         arm_d = 1'b0;
      end else if (trig_hit || tmo) begin
         arm_d = 1'b1;
      end
      rdy_n_d = (mode == XFER_BLOCK) ? !arm_d : empty;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_prev_q <= XFER_SINGLE;
         arm_q       <= 1'b0;
         rdy_n_q     <= 1'b1;
      end else begin
         mode_prev_q <= mode;
         arm_q       <= arm_d;
         rdy_n_q     <= rdy_n_d;
      end
   end

   assign rdy_n = rdy_n_q;

   // R4: single mode follows occupancy only
   assert_single_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XFER_SINGLE && level != '0) |=> !rdy_n);

   // R6: block mode releases on an empty FIFO
   assert_block_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XFER_BLOCK && empty) |=> rdy_n);

   // R6: once asserted it holds while data remains and nothing clears it
   assert_block_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XFER_BLOCK && mode_prev_q == XFER_BLOCK && !clr && !rdy_n && !empty)
      |=> !rdy_n);

   // R7: no arming from a timeout on an empty FIFO
   assert_no_empty_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XFER_BLOCK && rdy_n && empty) |=> rdy_n);

   // R10: a flush releases the line
   assert_flush_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XFER_BLOCK && clr) |=> rdy_n);

endmodule

// File: rtl/uart_dma_ready_gen.sv
module uart_dma_ready_gen
   import uart_rdy_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 8,
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_wr,
   input  logic [DW-1:0] ctl_wdata,
   input  logic [CW-1:0] tx_level,
   input  logic [CW-1:0] rx_level,
   input  logic          rx_trig_hit,
   input  logic          rx_timeout,
   output logic          tx_rdy_n,
   output logic          rx_rdy_n,
   output logic          fifo_on,
   output logic          dma_sel,
   output logic [1:0]    trig_sel,
   output logic          rx_flush,
   output logic          tx_flush
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uart_dma_ready_gen: DEPTH must be at least 2");
      end
      if (CW < $clog2(DEPTH + 1)) begin : g_bad_cw
         $error("uart_dma_ready_gen: CW cannot hold DEPTH");
      end
   endgenerate

   ctl_state_t ctl;
   xfer_mode_e mode;
   logic       rx_clr, tx_clr;

   uart_rdy_ctl #(.DW(DW)) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (ctl_wr),
      .wdata  (ctl_wdata),
      .state  (ctl),
      .rx_clr (rx_clr),
      .tx_clr (tx_clr)
   );

   assign mode = mode_of(ctl);

   uart_rdy_tx #(.DEPTH(DEPTH), .CW(CW)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .level (tx_level),
      .rdy_n (tx_rdy_n)
   );

   uart_rdy_rx #(.CW(CW)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .clr      (rx_clr),
      .level    (rx_level),
      .trig_hit (rx_trig_hit),
      .tmo      (rx_timeout),
      .rdy_n    (rx_rdy_n)
   );

   assign fifo_on  = ctl.en;
   assign dma_sel  = ctl.blk;
   assign trig_sel = ctl.trig;
   assign rx_flush = rx_clr;
   assign tx_flush = tx_clr;

   // R2: with the FIFO disabled a busy transmitter reads as not ready
   assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_on && tx_level != '0) |=> tx_rdy_n);

endmodule

// File: tb/tb_uart_dma_ready_gen.sv
module tb_uart_dma_ready_gen;

   localparam int unsigned DEPTH = 16;
   localparam int unsigned CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_wr = 1'b0;
   logic [7:0]    ctl_wdata = '0;
   logic [CW-1:0] tx_level = '0;
   logic [CW-1:0] rx_level = '0;
   logic          rx_trig_hit = 1'b0;
   logic          rx_timeout = 1'b0;
   logic          tx_rdy_n, rx_rdy_n, fifo_on, dma_sel, rx_flush, tx_flush;
   logic [1:0]    trig_sel;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   uart_dma_ready_gen #(.DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .tx_level(tx_level), .rx_level(rx_level), .rx_trig_hit(rx_trig_hit),
      .rx_timeout(rx_timeout), .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n),
      .fifo_on(fifo_on), .dma_sel(dma_sel), .trig_sel(trig_sel),
      .rx_flush(rx_flush), .tx_flush(tx_flush)
   );

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // Write the control word; returns at the negedge after the latching edge
   task automatic wr_ctl(input logic [7:0] d);
      @(negedge clk);
      ctl_wr = 1'b1;
      ctl_wdata = d;
      @(negedge clk);
      ctl_wr = 1'b0;
      ctl_wdata = '0;
   endtask

   task automatic t_reset();
      chk("R1 fifo_on", fifo_on, 0);
      chk("R1 dma_sel", dma_sel, 0);
      chk("R1 trig_sel", trig_sel, 0);
      chk("R1 rx_flush", rx_flush, 0);
      chk("R1 tx_flush", tx_flush, 0);
      chk("R1 tx_rdy_n", tx_rdy_n, 0);
      chk("R1 rx_rdy_n", rx_rdy_n, 1);
   endtask

   task automatic t_single_tx();
      tx_level = 1;
      #1 chk("R12 tx before edge", tx_rdy_n, 0);
      step(); chk("R3 tx one char", tx_rdy_n, 1);
      tx_level = 16; step(); chk("R3 tx full", tx_rdy_n, 1);
      tx_level = 0;
      #1 chk("R12 tx hold before edge", tx_rdy_n, 1);
      step(); chk("R3 tx empty", tx_rdy_n, 0);
   endtask

   task automatic t_single_rx();
      rx_level = 3;
      #1 chk("R12 rx before edge", rx_rdy_n, 1);
      step(); chk("R4 rx data", rx_rdy_n, 0);
      rx_trig_hit = 1'b1; rx_timeout = 1'b1; rx_level = 0;
      step(); chk("R4 rx empty flags ignored", rx_rdy_n, 1);
      rx_trig_hit = 1'b0; rx_timeout = 1'b0;
      step(); chk("R4 rx empty", rx_rdy_n, 1);
   endtask

   task automatic t_gate();
      wr_ctl(8'hC9);
      chk("R8 en set", fifo_on, 1);
      chk("R8 blk set", dma_sel, 1);
      chk("R8 trig set", trig_sel, 3);
      wr_ctl(8'h4E);
      chk("R8 en cleared", fifo_on, 0);
      chk("R8 blk kept", dma_sel, 1);
      chk("R8 trig kept", trig_sel, 3);
      chk("R8 no rx flush", rx_flush, 0);
      chk("R8 no tx flush", tx_flush, 0);
      wr_ctl(8'h41);
      chk("R8 blk cleared", dma_sel, 0);
      chk("R8 trig loaded", trig_sel, 1);
   endtask

   task automatic t_mode_gate();
      wr_ctl(8'h09);
      wr_ctl(8'h00);
      chk("R2 blk bit held", dma_sel, 1);
      tx_level = 5; step(); step();
      chk("R2 disabled acts single", tx_rdy_n, 1);
      wr_ctl(8'h09); step();
      chk("R2 enabled acts block", tx_rdy_n, 0);
   endtask

   task automatic t_block_tx();
      tx_level = 0;  step(); chk("R5 empty ready", tx_rdy_n, 0);
      tx_level = 15; step(); chk("R5 one free ready", tx_rdy_n, 0);
      tx_level = 16; step(); chk("R5 full not ready", tx_rdy_n, 1);
      tx_level = 15; step(); chk("R5 slot freed", tx_rdy_n, 0);
      tx_level = 0;
   endtask

   task automatic t_block_rx();
      rx_level = 3; step(); chk("R6 data no trigger", rx_rdy_n, 1);
      rx_trig_hit = 1'b1; step(); chk("R6 trigger arms", rx_rdy_n, 0);
      rx_trig_hit = 1'b0; rx_level = 2; step(); chk("R6 held below trigger", rx_rdy_n, 0);
      rx_level = 1; step(); chk("R6 held last char", rx_rdy_n, 0);
      rx_level = 0; step(); chk("R6 released empty", rx_rdy_n, 1);
      rx_level = 1; rx_timeout = 1'b1; step(); chk("R6 timeout arms", rx_rdy_n, 0);
      rx_timeout = 1'b0; step(); chk("R6 timeout held", rx_rdy_n, 0);
      rx_level = 0; step(); chk("R6 timeout released", rx_rdy_n, 1);
   endtask

   task automatic t_tmo_empty();
      rx_level = 0; rx_timeout = 1'b1; step();
      chk("R7 timeout empty", rx_rdy_n, 1);
      rx_timeout = 1'b0; rx_level = 2; step(); step();
      chk("R7 no stale arming", rx_rdy_n, 1);
      rx_level = 0; step();
   endtask

   task automatic t_flush();
      rx_level = 5; rx_trig_hit = 1'b1; step();
      rx_trig_hit = 1'b0;
      chk("R10 armed first", rx_rdy_n, 0);
      wr_ctl(8'h0B);
      chk("R9 rx flush pulse", rx_flush, 1);
      chk("R9 tx flush idle", tx_flush, 0);
      step();
      chk("R9 rx flush ends", rx_flush, 0);
      chk("R10 flush releases", rx_rdy_n, 1);
      step(); chk("R10 stays released", rx_rdy_n, 1);
      wr_ctl(8'h0D);
      chk("R9 tx flush pulse", tx_flush, 1);
      chk("R9 rx flush idle", rx_flush, 0);
      step(); chk("R9 tx flush ends", tx_flush, 0);
      rx_level = 0; step();
   endtask

   task automatic t_mode_change();
      rx_level = 5; rx_trig_hit = 1'b1; step();
      rx_trig_hit = 1'b0;
      chk("R11 armed first", rx_rdy_n, 0);
      wr_ctl(8'h01); step();
      chk("R11 single mode data", rx_rdy_n, 0);
      wr_ctl(8'h09); step();
      chk("R11 re-entry cleared", rx_rdy_n, 1);
      step(); chk("R11 still clear", rx_rdy_n, 1);
      rx_level = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_single_tx();
      t_single_rx();
      t_gate();
      t_mode_gate();
      t_block_tx();
      t_block_rx();
      t_tmo_empty();
      t_flush();
      t_mode_change();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule